// File: doc/BRIEF.md
# Power-Fail Store and Power-Up Recall Supervisor

This block watches the supply events of a volatile memory that has a nonvolatile shadow. Two comparator flags come in asynchronously. One says the backup capacitor supply is under the switch threshold. The other says it is under the lower reset threshold. Both flags are synchronized and then debounced. The filtered levels drive two controllers.

The recall controller keeps a pending-recall bit. That bit is set out of reset, because power-up counts as a deep loss. It is also set whenever the supply drops under the reset threshold. A shallow dip that stays above the reset threshold leaves the bit clear. Once the supply climbs back above the switch threshold, the controller issues a recall pulse. It then blocks memory access for a fixed restore window.

The store controller tracks whether the memory has been written since the last nonvolatile cycle. When the supply falls through the switch threshold, it pulls the shared busy line low for a short pulse. During that pulse it watches the sensed pin level. Three outcomes follow:
- The store goes ahead only if a write is outstanding and the pin was really seen low.
- It is abandoned if nothing was written.
- It is abandoned if an outside driver held the pin high.

An outside agent can also request a store by pulling the busy line low. A strap input turns the automatic store off. Every duration is a parameter in clock cycles.

Top module: `pf_supervisor`

## Requirements
- R1: After reset `busy_pd_o`, `store_req_o`, `recall_req_o` and `access_blk_o` are 0. `write_inh_o` is 1, because both filtered flags reset to the below-threshold state.
- R2: Each comparator flag passes through two synchronizer flops. It then has to hold its new value for DEB_CYC consecutive cycles before the filtered level changes, so a pulse of fewer cycles has no effect. A flag driven before clock edge 1 changes the filtered level at edge 2+DEB_CYC.
- R3: A recall is pending after reset and after any filtered below-reset indication. Once both filtered flags are low, `recall_req_o` pulses for one cycle at the next edge (edge 3+DEB_CYC after the flags fall). `access_blk_o` is high for RESTORE_CYC cycles starting in that same cycle.
- R4: A dip below the switch threshold that does not reach the reset threshold produces no recall pulse when the supply returns.
- R5: With the strap low, a filtered rise of the below-switch flag makes `busy_pd_o` go high one cycle later (edge 3+DEB_CYC) and stay high for PULSE_CYC cycles.
- R6: If no write has been accepted since the last store or recall, the busy pulse ends with `busy_pd_o` released and no `store_req_o`.
- R7: If a write is outstanding and the pin was seen low, `store_req_o` pulses for one cycle as the busy pulse ends (edge 3+DEB_CYC+PULSE_CYC). `busy_pd_o` then stays high for a further STORE_CYC cycles. The store clears the written state.
- R8: `write_inh_o` is high while the filtered below-switch flag is set, while `busy_pd_o` is high, and while `access_blk_o` is high. A `mem_write_i` pulse accepted while it is high does not mark the memory as written.
- R9: With `strap_i` high, a falling supply causes no busy pulse and no store.
- R10: A falling edge on the busy line while the store controller is idle is an external request. It starts a store (`store_req_o` high and `busy_pd_o` held for STORE_CYC cycles) at edge 3 after the pin falls. This happens only if the memory is written and the supply is above the switch threshold. Otherwise the request is ignored and the written state is kept.
- R11: If `busy_sense_i` (1 = pin high) stays high for the whole busy pulse, the attempt is aborted. No `store_req_o` is issued and the pull-down is released, even when a write is outstanding.
- R12: A recall clears the written state, so a later falling supply with no new write issues no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| below_sw_i | input | 1 | Async comparator: capacitor supply under switch threshold |
| below_rst_i | input | 1 | Async comparator: capacitor supply under reset threshold |
| strap_i | input | 1 | 1 disables automatic store on power loss |
| mem_write_i | input | 1 | One pulse per memory write attempt |
| busy_sense_i | input | 1 | Sensed busy pin level, 1 = high |
| busy_pd_o | output | 1 | Open-drain pull-down enable for the busy pin |
| store_req_o | output | 1 | One-cycle store start pulse |
| recall_req_o | output | 1 | One-cycle recall start pulse |
| write_inh_o | output | 1 | Memory write inhibit |
| access_blk_o | output | 1 | Memory access blocked during restore |

## Verification
Every result is tied to a fixed edge count after its stimulus:
- The bench drives each stimulus on a falling clock edge and calls the next rising edge edge 1.
- A supply flag reaches the filtered level at edge 2+DEB_CYC.
- The recall pulse, and the start of the busy pulse, follow at edge 3+DEB_CYC.
- The store pulse arrives at edge 3+DEB_CYC+PULSE_CYC.
- A pin-initiated store starts at edge 3 after the pin falls.

Outputs are sampled on each falling edge inside a counted window. The bench records both the index of the first cycle an output is high and the number of high cycles, then compares them with those offsets and with PULSE_CYC, STORE_CYC and RESTORE_CYC. Whether a store is expected comes from a written-state model that the bench updates only for writes it knows were accepted.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_STORE = 2'd2
  } st_e;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_SW   = 0;
  localparam int unsigned FLAG_RST  = 1;
endpackage

// File: rtl/pf_flag_filter.sv
module pf_flag_filter #(
  parameter int unsigned DEB_CYC = 8,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      filt_o <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        filt_o <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: filtered level only moves to a value the synchronizer already held
  p_filt_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_o != $past(filt_o)) |-> ($past(s2_q) == filt_o));
endmodule

// File: rtl/pf_recall_ctl.sv
module pf_recall_ctl #(
  parameter int unsigned RESTORE_CYC = 55000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_f_i,
  input  logic rst_f_i,
  output logic recall_req_o,
  output logic restore_o
);
  localparam int unsigned CW = $clog2(RESTORE_CYC + 1);

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start = pend_q && !restore_o && !sw_f_i && !rst_f_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b1;
      recall_req_o <= 1'b0;
      restore_o    <= 1'b0;
      cnt_q        <= '0;
    end else begin
      recall_req_o <= 1'b0;
      if (rst_f_i) pend_q <= 1'b1;
      if (start) begin
        pend_q       <= 1'b0;
        recall_req_o <= 1'b1;
        restore_o    <= 1'b1;
        cnt_q        <= CW'(RESTORE_CYC - 1);
      end else if (restore_o) begin
        if (cnt_q == '0) restore_o <= 1'b0;
        else             cnt_q     <= cnt_q - 1'b1;
      end
    end
  end

  p_recall_above_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |-> !$past(sw_f_i));
  p_blk_with_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_o) |-> recall_req_o);
  p_recall_needs_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |-> $past(pend_q));
endmodule

// File: rtl/pf_store_ctl.sv
module pf_store_ctl
  import pf_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 100,
  parameter int unsigned STORE_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_f_i,
  input  logic strap_i,
  input  logic mem_write_i,
  input  logic inh_i,
  input  logic nv_clr_i,
  input  logic sense_i,
  output logic busy_pd_o,
  output logic store_req_o
);
  localparam int unsigned MAXC = (PULSE_CYC > STORE_CYC) ? PULSE_CYC : STORE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q, dirty_q, sw_q;
  logic          p1_q, p2_q, p3_q;
  logic          auto_trig, ext_trig, pin_low;

  assign pin_low   = !p2_q;
  assign auto_trig = sw_f_i && !sw_q && !strap_i;
  assign ext_trig  = p3_q && pin_low && !sw_f_i && dirty_q;
  assign busy_pd_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= 1'b1;
      p2_q <= 1'b1;
      p3_q <= 1'b1;
      sw_q <= 1'b1;
    end else begin
      p1_q <= sense_i;
      p2_q <= p1_q;
      p3_q <= p2_q;
      sw_q <= sw_f_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      dirty_q <= 1'b0;
    else if (store_req_o || nv_clr_i) dirty_q <= 1'b0;
    else if (mem_write_i && !inh_i)   dirty_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      seen_q      <= 1'b0;
      store_req_o <= 1'b0;
    end else begin
      store_req_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (auto_trig) begin
            st_q   <= ST_PULSE;
            cnt_q  <= CW'(PULSE_CYC - 1);
            seen_q <= 1'b0;
          end else if (ext_trig) begin
            st_q        <= ST_STORE;
            cnt_q       <= CW'(STORE_CYC - 1);
            store_req_o <= 1'b1;
          end
        end
        ST_PULSE: begin
          if (pin_low) seen_q <= 1'b1;
          if (cnt_q == '0) begin
            if ((seen_q || pin_low) && dirty_q) begin
              st_q        <= ST_STORE;
              cnt_q       <= CW'(STORE_CYC - 1);
              store_req_o <= 1'b1;
            end else begin
              st_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STORE: begin
          if (cnt_q == '0) st_q  <= ST_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_req_needs_dirty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> $past(dirty_q));
  p_req_holds_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> busy_pd_o);
  p_inh_keeps_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dirty_q && inh_i) |=> !dirty_q);
  p_strap_no_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && strap_i) |=> (st_q != ST_PULSE));
  p_ext_below_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && sw_f_i) |=> !store_req_o);
  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PULSE && cnt_q == '0 && !seen_q && !pin_low) |=> (!store_req_o && !busy_pd_o));
endmodule

// File: rtl/pf_supervisor.sv
module pf_supervisor
  import pf_pkg::*;
#(
  parameter int unsigned DEB_CYC     = 8,
  parameter int unsigned PULSE_CYC   = 100,
  parameter int unsigned STORE_CYC   = 1000000,
  parameter int unsigned RESTORE_CYC = 55000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_sw_i,
  input  logic below_rst_i,
  input  logic strap_i,
  input  logic mem_write_i,
  input  logic busy_sense_i,
  output logic busy_pd_o,
  output logic store_req_o,
  output logic recall_req_o,
  output logic write_inh_o,
  output logic access_blk_o
);
  logic [NUM_FLAGS-1:0] raw, filt;

  assign raw[FLAG_SW]  = below_sw_i;
  assign raw[FLAG_RST] = below_rst_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
    pf_flag_filter #(.DEB_CYC(DEB_CYC), .RST_VAL(1'b1)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .filt_o (filt[g])
    );
  end

  pf_recall_ctl #(.RESTORE_CYC(RESTORE_CYC)) u_rcl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_f_i       (filt[FLAG_SW]),
    .rst_f_i      (filt[FLAG_RST]),
    .recall_req_o (recall_req_o),
    .restore_o    (access_blk_o)
  );

  pf_store_ctl #(.PULSE_CYC(PULSE_CYC), .STORE_CYC(STORE_CYC)) u_sto (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_f_i      (filt[FLAG_SW]),
    .strap_i     (strap_i),
    .mem_write_i (mem_write_i),
    .inh_i       (write_inh_o),
    .nv_clr_i    (recall_req_o),
    .sense_i     (busy_sense_i),
    .busy_pd_o   (busy_pd_o),
    .store_req_o (store_req_o)
  );

  assign write_inh_o = filt[FLAG_SW] || busy_pd_o || access_blk_o;
endmodule

// File: tb/sim_pf_supervisor.sv
module sim_pf_supervisor;
  localparam int DEB = 3, PUL = 6, STO = 20, RES = 15;

  // table: {write_first, strap, hold_pin_high}
  localparam logic [2:0] VEC [6] = '{3'b100, 3'b000, 3'b110, 3'b101, 3'b000, 3'b011};

  logic clk = 0, rst_ni = 0;
  logic below_sw = 1, below_rst = 1, strap = 0, mem_write = 0;
  logic hold_hi = 0, ext_low = 0;
  logic busy_pd, store_req, recall_req, write_inh, access_blk, sense;

  int checks = 0, fails = 0;
  int busy_n, busy_at, sto_n, sto_at, rcl_n, rcl_at, blk_n;
  bit dirty_m = 0;

  always #5 clk = ~clk;

  assign sense = hold_hi ? 1'b1 : !(busy_pd || ext_low);

  pf_supervisor #(.DEB_CYC(DEB), .PULSE_CYC(PUL), .STORE_CYC(STO), .RESTORE_CYC(RES)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .below_sw_i(below_sw), .below_rst_i(below_rst),
    .strap_i(strap), .mem_write_i(mem_write), .busy_sense_i(sense),
    .busy_pd_o(busy_pd), .store_req_o(store_req), .recall_req_o(recall_req),
    .write_inh_o(write_inh), .access_blk_o(access_blk));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // window of n cycles; releases ext_low at rel_ext and below_sw at rel_sw (0 = never)
  task automatic win(input int n, input int rel_ext, input int rel_sw);
    busy_n = 0; busy_at = 0; sto_n = 0; sto_at = 0; rcl_n = 0; rcl_at = 0; blk_n = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (busy_pd) begin busy_n++; if (busy_at == 0) busy_at = i; end
      if (store_req) begin sto_n++; if (sto_at == 0) sto_at = i; end
      if (recall_req) begin rcl_n++; if (rcl_at == 0) rcl_at = i; end
      if (access_blk) blk_n++;
      if (i == rel_ext) ext_low = 0;
      if (i == rel_sw) below_sw = 0;
    end
  endtask

  task automatic do_write(input string req, input bit accept);
    chk(req, write_inh, !accept);
    mem_write = 1;
    @(negedge clk);
    mem_write = 0;
    if (accept) dirty_m = 1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 busy", busy_pd, 0);
    chk("R1 store", store_req, 0);
    chk("R1 recall", recall_req, 0);
    chk("R1 blk", access_blk, 0);
    chk("R1 inh", write_inh, 1);

    // R3 power-up recall
    below_sw = 0; below_rst = 0;
    win(30, 0, 0);
    chk("R3 recall count", rcl_n, 1);
    chk("R3 recall cycle", rcl_at, 3 + DEB);
    chk("R3 restore len", blk_n, RES);
    chk("R5 no busy on rise", busy_n, 0);
    chk("R8 inh clear", write_inh, 0);

    // table of brownouts (R4-R7, R9, R11)
    foreach (VEC[k]) begin
      bit wr = VEC[k][2], st = VEC[k][1], hh = VEC[k][0];
      bit exp_sto;
      int exp_busy;
      strap = st; hold_hi = hh;
      if (wr) do_write("R8 write accepted", 1);
      exp_sto  = !st && !hh && dirty_m;
      exp_busy = st ? 0 : PUL + (exp_sto ? STO : 0);
      below_sw = 1;
      win(40, 0, 0);
      chk("R5/R9 busy len", busy_n, exp_busy);
      if (!st) chk("R5 busy start", busy_at, 3 + DEB);
      chk("R6/R7/R11 store count", sto_n, exp_sto);
      if (exp_sto) begin
        chk("R7 store cycle", sto_at, 3 + DEB + PUL);
        dirty_m = 0;
      end
      chk("R8 inh below", write_inh, 1);
      hold_hi = 0;
      below_sw = 0;
      win(30, 0, 0);
      chk("R4 no recall", rcl_n, 0);
      chk("R8 inh released", write_inh, 0);
    end
    strap = 0;

    // R2 glitch shorter than filter
    below_sw = 1;
    win(25, 0, 2);
    chk("R2 glitch busy", busy_n, 0);
    chk("R2 glitch inh", write_inh, 0);

    // R10 pin request
    do_write("R10 write", 1);
    ext_low = 1;
    win(30, 4, 0);
    chk("R10 ext store", sto_n, 1);
    chk("R10 ext cycle", sto_at, 3);
    chk("R10 ext busy", busy_n, STO);
    dirty_m = 0;
    ext_low = 1;
    win(30, 4, 0);
    chk("R10 clean ignored", sto_n, 0);

    do_write("R10 write2", 1);
    strap = 1; below_sw = 1;
    win(20, 0, 0);
    ext_low = 1;
    win(20, 4, 0);
    chk("R10 below ignored", sto_n, 0);
    below_sw = 0;
    win(20, 0, 0);
    strap = 0;
    ext_low = 1;
    win(30, 4, 0);
    chk("R10 dirty kept", sto_n, 1);
    dirty_m = 0;

    // R8 write during inhibit is dropped
    strap = 1; below_sw = 1;
    win(20, 0, 0);
    do_write("R8 write inhibited", 0);
    below_sw = 0;
    win(20, 0, 0);
    strap = 0; below_sw = 1;
    win(40, 0, 0);
    chk("R8 no store after inhibited write", sto_n, 0);
    below_sw = 0;
    win(20, 0, 0);

    // R12 recall clears written state; R3 deep loss
    strap = 1;
    do_write("R12 write", 1);
    below_sw = 1; below_rst = 1;
    win(20, 0, 0);
    chk("R9 strap no busy", busy_n, 0);
    below_sw = 0; below_rst = 0;
    win(30, 0, 0);
    chk("R3 deep loss recall", rcl_n, 1);
    chk("R3 deep recall cycle", rcl_at, 3 + DEB);
    dirty_m = 0;
    strap = 0; below_sw = 1;
    win(40, 0, 0);
    chk("R12 no store after recall", sto_n, 0);
    chk("R12 busy pulse only", busy_n, PUL);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule